// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier with Step Counter

This block multiplies two unsigned operands one bit per step. A single accumulator register, one bit wider than the full product, does two jobs. Its low half starts out holding the multiplier. Its upper part gathers partial sums while the register shifts right. The multiplicand sits in its own register. A narrow adder combines the multiplicand with the upper accumulator bits and keeps the carry.

Control has two parts. The sequencer decides, from the start request and the accumulator's lowest bit, whether a step is add-then-shift or shift-only. A separate step counter counts shifts and raises a last-step flag when the final shift is due. Once that shift finishes, a one-cycle done pulse marks the product as valid. The product then stays on the output until the next start is accepted.

Top module: `shift_add_mul`

## Requirements
- R1: While reset is asserted, `product` is 0 and `done` is 0.
- R2: A high `start` in the idle state, sampled at a clock edge, captures `multiplicand`. At that same edge, the accumulator takes `multiplier` in its low OP_W bits and zeros in its upper OP_W+1 bits. After the edge, `product` equals the multiplier.
- R3: When the accumulator LSB is 1 in a test step, the accumulator's upper OP_W+1 bits are replaced by the sum of its bits [2*OP_W-1:OP_W] and the multiplicand, with the carry kept in bit 2*OP_W. The next cycle is a shift.
- R4: When the accumulator LSB is 0 in a test step, the step is a shift only and takes a single cycle.
- R5: Each shift moves all 2*OP_W+1 accumulator bits right by one and fills the top bit with 0.
- R6: The step counter is cleared on load and advances on every shift. Its last-step flag is high when OP_W-1 shifts have already happened. So `done` rises exactly OP_W + popcount(multiplier) clock edges after the load edge.
- R7: `done` is high for exactly one cycle, after the shift made while the last-step flag was high. In that cycle `product` equals the unsigned product of the captured operands.
- R8: `start` is ignored during a multiplication and in the done cycle. No reload happens and `product` is unchanged.
- R9: After `done`, `product` holds its value in idle until a new start is accepted.
- R10: Operand inputs are sampled only at the load edge. Changing them during a multiplication does not change the result.
- R11: A start in the first idle cycle after `done` is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request to begin a multiplication, honoured only in idle |
| multiplicand | input | OP_W | Unsigned multiplicand |
| multiplier | input | OP_W | Unsigned multiplier |
| product | output | 2*OP_W | Low 2*OP_W accumulator bits; final product after done |
| done | output | 1 | One-cycle pulse when the product is valid |

## Verification
Several properties are checked on every cycle. Only one of load, add and shift may be active at a time. A load zeros the upper accumulator and places the multiplier in the low bits. An add writes the carried sum into the upper bits. A shift is an exact one-bit right shift. The counter clears on load and steps on each shift. Done only follows a shift made with the last-step flag set, and it never lasts two cycles. Other behaviour can only be shown by the bench's scenarios: the full product over every operand pair, the latency that depends on the multiplier's set bits, and the immunity to operand changes and stray start pulses during a run. The bench's reference model, compared on every clock, also checks the back-to-back restart and the value held in idle.

// File: rtl/sam_pkg.sv
package sam_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_TEST  = 2'd1,
    SEQ_ADDED = 2'd2,
    SEQ_DONE  = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic load;
    logic add;
    logic shift;
  } acc_ctrl_t;

endpackage

// File: rtl/sam_datapath.sv
module sam_datapath
  import sam_pkg::*;
#(
  parameter int OP_W  = 4,
  localparam int ACC_W = 2 * OP_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  acc_ctrl_t        ctrl,
  input  logic [OP_W-1:0]  mcand_in,
  input  logic [OP_W-1:0]  mplr_in,
  output logic [ACC_W-1:0] acc,
  output logic [OP_W-1:0]  mcand,
  output logic             lsb
);

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [OP_W-1:0]  mcand_q;
  logic [OP_W:0]    sum;

  assign sum = {1'b0, acc_q[2*OP_W-1:OP_W]} + {1'b0, mcand_q};

  always_comb begin
    acc_d = acc_q;
    if (ctrl.load) begin
      acc_d = {{(OP_W+1){1'b0}}, mplr_in};
    end else if (ctrl.add) begin
      acc_d = {sum, acc_q[OP_W-1:0]};
    end else if (ctrl.shift) begin
      acc_d = {1'b0, acc_q[ACC_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (ctrl.load || ctrl.add || ctrl.shift) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
    end else if (ctrl.load) begin
      mcand_q <= mcand_in;
    end
  end

  assign acc   = acc_q;
  assign mcand = mcand_q;
  assign lsb   = acc_q[0];

endmodule

// File: rtl/sam_step_counter.sv
module sam_step_counter #(
  parameter int OP_W  = 4,
  localparam int CNT_W = (OP_W > 1) ? $clog2(OP_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic [CNT_W-1:0] count,
  output logic             last
);

  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(OP_W - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (step) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear || step) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;
  assign last  = (cnt_q == LAST_VAL);

endmodule

// File: rtl/sam_sequencer.sv
module sam_sequencer
  import sam_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       lsb,
  input  logic       last,
  output acc_ctrl_t  ctrl,
  output logic       done
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    ctrl       = '0;
    done       = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          ctrl.load = 1'b1;
          state_d   = SEQ_TEST;
        end
      end
      SEQ_TEST: begin
        if (lsb) begin
          ctrl.add = 1'b1;
          state_d  = SEQ_ADDED;
        end else begin
          ctrl.shift = 1'b1;
          state_d    = last ? SEQ_DONE : SEQ_TEST;
        end
      end
      SEQ_ADDED: begin
        ctrl.shift = 1'b1;
        state_d    = last ? SEQ_DONE : SEQ_TEST;
      end
      SEQ_DONE: begin
        done    = 1'b1;
        state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul
  import sam_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OP_W-1:0]   multiplicand,
  input  logic [OP_W-1:0]   multiplier,
  output logic [2*OP_W-1:0] product,
  output logic              done
);

  localparam int ACC_W = 2 * OP_W + 1;
  localparam int CNT_W = (OP_W > 1) ? $clog2(OP_W) : 1;

  logic             rst_meta_q, rst_sync_q;
  acc_ctrl_t        ctrl;
  logic [ACC_W-1:0] acc;
  logic [OP_W-1:0]  mcand;
  logic             lsb;
  logic [CNT_W-1:0] step_cnt;
  logic             last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  sam_sequencer u_seq (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .start (start),
    .lsb   (lsb),
    .last  (last),
    .ctrl  (ctrl),
    .done  (done)
  );

  sam_step_counter #(.OP_W(OP_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .clear (ctrl.load),
    .step  (ctrl.shift),
    .count (step_cnt),
    .last  (last)
  );

  sam_datapath #(.OP_W(OP_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .ctrl     (ctrl),
    .mcand_in (multiplicand),
    .mplr_in  (multiplier),
    .acc      (acc),
    .mcand    (mcand),
    .lsb      (lsb)
  );

  assign product = acc[2*OP_W-1:0];

endmodule

// File: rtl/sam_checker.sv
module sam_checker #(
  parameter int OP_W  = 4,
  localparam int ACC_W = 2 * OP_W + 1,
  localparam int CNT_W = (OP_W > 1) ? $clog2(OP_W) : 1
) (
  input logic             clk,
  input logic             rst_ns,
  input logic             load,
  input logic             add,
  input logic             shift,
  input logic             done,
  input logic             last,
  input logic [ACC_W-1:0] acc,
  input logic [OP_W-1:0]  mcand,
  input logic [OP_W-1:0]  mplr_in,
  input logic [CNT_W-1:0] step_cnt
);

  p_ctrl_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    $onehot0({load, add, shift}));

  p_load_fills_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    load |=> (acc[ACC_W-1:OP_W] == '0) && (acc[OP_W-1:0] == $past(mplr_in)));

  p_add_carry_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    add |=> (acc[ACC_W-1:OP_W] ==
             ({1'b0, $past(acc[2*OP_W-1:OP_W])} + {1'b0, $past(mcand)})) && shift);

  p_shift_right_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    shift |=> acc == {1'b0, $past(acc[ACC_W-1:1])});

  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    shift |=> step_cnt == CNT_W'($past(step_cnt) + 1'b1));

  p_count_clear_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    load |=> step_cnt == '0);

  p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    done |-> ($past(shift) && $past(last)));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    done |=> !done);

endmodule

bind shift_add_mul sam_checker #(.OP_W(OP_W)) u_chk (
  .clk      (clk),
  .rst_ns   (rst_sync_q),
  .load     (ctrl.load),
  .add      (ctrl.add),
  .shift    (ctrl.shift),
  .done     (done),
  .last     (last),
  .acc      (acc),
  .mcand    (mcand),
  .mplr_in  (multiplier),
  .step_cnt (step_cnt)
);

// File: tb/tb_shift_add_mul.sv
module tb_shift_add_mul;

  localparam int OP_W   = 4;
  localparam int CLK_NS = 10;

  logic              clk;
  logic              rst_n;
  logic              start;
  logic [OP_W-1:0]   mc;
  logic [OP_W-1:0]   mp;
  logic [2*OP_W-1:0] product;
  logic              done;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;

  shift_add_mul #(.OP_W(OP_W)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .multiplicand (mc),
    .multiplier   (mp),
    .product      (product),
    .done         (done)
  );

  initial clk = 1'b0;
  always #(CLK_NS / 2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase 0 idle, 1 test, 2 after add, 3 done
  int m_ph    = 0;
  int m_acc   = 0;
  int m_mc    = 0;
  int m_shift = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_acc = 0; m_mc = 0; m_shift = 0;
    end else begin
      case (m_ph)
        0: if (start) begin
             m_acc = int'(mp); m_mc = int'(mc); m_shift = 0; m_ph = 1;
           end
        1: if ((m_acc % 2) == 1) begin
             m_acc = m_acc + (m_mc << OP_W); m_ph = 2;
           end else begin
             m_acc = m_acc / 2; m_shift++;
             m_ph = (m_shift == OP_W) ? 3 : 1;
           end
        2: begin
             m_acc = m_acc / 2; m_shift++;
             m_ph = (m_shift == OP_W) ? 3 : 1;
           end
        default: m_ph = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      string tag;
      case (m_ph)
        0: tag = "R9";
        2: tag = "R3";
        3: tag = "R7";
        default: tag = "R5";
      endcase
      check(int'(product) == (m_acc % (1 << (2*OP_W))), tag, int'(product),
            m_acc % (1 << (2*OP_W)));
      check(done == (m_ph == 3), "R7", int'(done), int'(m_ph == 3));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  // Called at a negedge with the design idle; returns at a negedge in idle.
  task automatic run_op(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b,
                        input bit disturb);
    int edges;
    int exp_lat;
    mc = a; mp = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    edges = 0;
    check(int'(product) == int'(b), "R2", int'(product), int'(b));
    exp_lat = OP_W + $countones(b);
    while (!done && edges < 40) begin
      if (disturb) begin
        mc = OP_W'($urandom()); mp = OP_W'($urandom());
        start = 1'($urandom_range(0, 1));
      end
      @(negedge clk);
      edges++;
    end
    // R6: latency depends on the number of set multiplier bits; R4 when b has zeros
    check(edges == exp_lat, "R6", edges, exp_lat);
    check(int'(product) == int'(a) * int'(b), "R7", int'(product), int'(a) * int'(b));
    start = disturb;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R7", int'(done), 0);
    check(int'(product) == int'(a) * int'(b), "R9", int'(product), int'(a) * int'(b));
    if (disturb) begin
      mc = OP_W'($urandom()); mp = OP_W'($urandom());
      @(negedge clk);
      // R8: start in the done cycle and R10: operand changes left the result alone
      check(int'(product) == int'(a) * int'(b), "R8", int'(product), int'(a) * int'(b));
      check(int'(product) == int'(a) * int'(b), "R10", int'(product), int'(a) * int'(b));
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; mc = '0; mp = '0;
    repeat (3) @(negedge clk);
    check(product == '0, "R1", int'(product), 0);
    check(done == 1'b0, "R1", int'(done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: every pair, each started in the first idle cycle after the last done
    for (int a = 0; a < (1 << OP_W); a++) begin
      for (int b = 0; b < (1 << OP_W); b++) begin
        run_op(OP_W'(a), OP_W'(b), 1'b0);
      end
    end

    // R8 / R10: stray starts and changing operands during the run
    for (int i = 0; i < 60; i++) begin
      run_op(OP_W'($urandom()), OP_W'($urandom()), 1'b1);
    end
    run_op('1, '1, 1'b1);
    run_op('0, '1, 1'b1);

    // R9: idle hold over several cycles
    repeat (5) @(negedge clk);
    check(int'(product) == 0, "R9", int'(product), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule